// File: doc/BRIEF.md
# Packed Variable-Length CAN Receive Buffer

This block is the receive store of a CAN controller. Every frame that the acceptance logic passes arrives as a one-cycle strobe carrying the identifier, the extended and remote flags, the length code and up to eight data bytes. The block packs the frame into a record of 3 to 13 bytes and appends it to a circular byte array. Nothing is padded, so short frames take little space and the array holds as many records as their sizes allow.

The host sees only the oldest record. It reads it through a 16-position byte window whose offsets count from the read pointer. A release command frees that record. The block works out how far to move the read pointer from the header byte of the stored record, so it never keeps a table of record lengths. A frame that does not fit in the free space is dropped and raises a sticky overrun flag, which a separate command clears. The buffer accepts nothing while the controller is in its reset mode, and it empties itself on the cycle the controller leaves that mode.

Top module: `can_rx_pack_buf`

## Requirements
- R1: After the asynchronous reset, `buf_ready` and `overrun` are 0.
- R2: A standard frame (`frm_ext`=0) is stored as these bytes: a header {bit7 extended, bit6 remote, bits5:4 zero, bits3:0 length code}, then ID[10:3], then {ID[2:0], 5'b0}, then the data bytes in order, with `frm_data[7:0]` as data byte 0. The record is 3 + data-byte count long.
- R3: An extended frame is stored as the header, then ID[28:21], ID[20:13] and ID[12:5], then {ID[4:0], 3'b0}, then the data bytes. The record is 5 + data-byte count long.
- R4: A remote frame stores no data bytes. Its header still carries the length code it was given.
- R5: A length code above 8 is stored in the header as 8, and 8 data bytes are stored.
- R6: Window offset k (0..12) returns the byte at address (read pointer + k) mod capacity. Offsets 13 to 15 return 0.
- R7: A release advances the read pointer by 3, plus 2 when header bit 7 is set, plus the header length code when header bit 6 is clear. `buf_ready` clears once no message remains.
- R8: A release while no message is stored changes nothing.
- R9: A frame whose record would make the used byte count exceed capacity is dropped, sets `overrun`, and leaves the stored records untouched. A record that fills the buffer exactly is accepted.
- R10: `ovr_clear` clears `overrun`. When a drop and `ovr_clear` fall in the same cycle, the flag is set.
- R11: Frames are ignored while `reset_mode` is 1. On the first cycle after `reset_mode` falls, the contents, pointers and counts are cleared, and `overrun` keeps its value.
- R12: The write pointer wraps modulo capacity. A record that straddles the end of the array reads back contiguously through the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode | input | 1 | Controller is in reset mode |
| frm_valid | input | 1 | One-cycle strobe for an accepted frame |
| frm_ext | input | 1 | Extended identifier |
| frm_rtr | input | 1 | Remote frame |
| frm_dlc | input | 4 | Length code |
| frm_id | input | 29 | Identifier (standard frames use bits 10:0) |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rel_req | input | 1 | Release the oldest record |
| ovr_clear | input | 1 | Clear the overrun flag |
| win_off | input | 4 | Window byte offset |
| win_data | output | 8 | Byte at the window offset |
| buf_ready | output | 1 | At least one message is stored |
| overrun | output | 1 | A frame was dropped for lack of space |

## Verification
The hardest case to reach is a record that straddles the end of the array while the buffer sits close to full. To get there, the stimulus stores five 11-byte standard records, releases three of them, and then writes a 13-byte extended record that starts at byte 55. The exact-fill boundary is reached with four 13-byte records and one 12-byte record, which together fill all 64 bytes. The same-cycle drop-and-clear case is reached by strobing a frame into the full buffer with `ovr_clear` asserted.

// File: rtl/can_rxbuf_pkg.sv
package can_rxbuf_pkg;
   localparam int REC_MAX  = 13;   // longest packed record in bytes
   localparam int LEN_W    = 4;    // width of a record length / window offset
   localparam int WIN_SIZE = 13;   // readable window positions
   typedef logic [(1 << LEN_W)-1:0][7:0] rec_bytes_t;
endpackage

// File: rtl/can_rxbuf_pack.sv
module can_rxbuf_pack
   import can_rxbuf_pkg::*;
(
   input  logic              ext,
   input  logic              rtr,
   input  logic [3:0]        dlc,
   input  logic [28:0]       id,
   input  logic [63:0]       data,
   output rec_bytes_t        bytes,
   output logic [LEN_W-1:0]  len
);
   logic [3:0]       dlc_c;
   logic [3:0]       n_data;
   logic [LEN_W-1:0] base;

   always_comb begin
      dlc_c  = (dlc > 4'd8) ? 4'd8 : dlc;
      n_data = rtr ? 4'd0 : dlc_c;
      base   = ext ? LEN_W'(5) : LEN_W'(3);
      bytes    = '0;
      bytes[0] = {ext, rtr, 2'b00, dlc_c};
      if (ext) begin
         bytes[1] = id[28:21];
         bytes[2] = id[20:13];
         bytes[3] = id[12:5];
         bytes[4] = {id[4:0], 3'b000};
      end else begin
         bytes[1] = id[10:3];
         bytes[2] = {id[2:0], 5'b00000};
      end
      for (int k = 0; k < 8; k++) begin
         if (4'(k) < n_data) bytes[base + LEN_W'(k)] = data[8*k +: 8];
      end
      len = base + n_data;
   end
endmodule

// File: rtl/can_rxbuf_store.sv
module can_rxbuf_store
   import can_rxbuf_pkg::*;
#(
   parameter int CAP = 64,
   parameter int AW  = $clog2(CAP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [AW-1:0]     wr_base,
   input  logic [LEN_W-1:0]  wr_len,
   input  rec_bytes_t        wr_bytes,
   input  logic [AW-1:0]     rd_base,
   input  logic [LEN_W-1:0]  rd_off,
   output logic [7:0]        rd_data,
   output logic [7:0]        hdr
);
   logic [7:0] mem [CAP];

   for (genvar i = 0; i < CAP; i++) begin : g_slot
      logic [AW-1:0] rel;
      logic [7:0]    slot_q;
      assign rel = AW'(i) - wr_base;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         slot_q <= '0;
         else if (clr)                       slot_q <= '0;
         else if (we && rel < AW'(wr_len))   slot_q <= wr_bytes[rel[LEN_W-1:0]];
      end
      assign mem[i] = slot_q;
   end

   logic [AW-1:0] rd_addr;
   assign rd_addr = rd_base + AW'(rd_off);
   assign rd_data = (rd_off < LEN_W'(WIN_SIZE)) ? mem[rd_addr] : 8'h00;
   assign hdr     = mem[rd_base];
endmodule

// File: rtl/can_rxbuf_ctrl.sv
module can_rxbuf_ctrl
   import can_rxbuf_pkg::*;
#(
   parameter int CAP = 64,
   parameter int AW  = $clog2(CAP),
   parameter int UW  = $clog2(CAP + REC_MAX + 1),
   parameter int MW  = $clog2(CAP / 3 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reset_mode,
   input  logic              frm_valid,
   input  logic [LEN_W-1:0]  rec_len,
   input  logic              rel_req,
   input  logic              ovr_clear,
   input  logic [7:0]        hdr,
   output logic              clr,
   output logic              we,
   output logic [AW-1:0]     wr_ptr,
   output logic [AW-1:0]     rd_ptr,
   output logic              buf_ready,
   output logic              overrun
);
   logic          mode_q;
   logic [UW-1:0] used_q;
   logic [MW-1:0] msg_q;
   logic [AW-1:0] wr_q, rd_q;
   logic          ovr_q;
   logic          take, fits, drop, rel_ok;
   logic [LEN_W-1:0] rel_len;

   assign clr    = mode_q && !reset_mode;
   assign take   = frm_valid && !reset_mode && !clr;
   assign fits   = (used_q + UW'(rec_len)) <= UW'(CAP);
   assign we     = take && fits;
   assign drop   = take && !fits;
   assign rel_ok = rel_req && (msg_q != '0) && !clr;
   assign rel_len = LEN_W'(3) + (hdr[7] ? LEN_W'(2) : LEN_W'(0))
                  + (hdr[6] ? LEN_W'(0) : hdr[3:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b1;
         used_q <= '0;
         msg_q  <= '0;
         wr_q   <= '0;
         rd_q   <= '0;
         ovr_q  <= 1'b0;
      end else begin
         mode_q <= reset_mode;
         if (clr) begin
            used_q <= '0;
            msg_q  <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
         end else begin
            used_q <= used_q + (we ? UW'(rec_len) : '0) - (rel_ok ? UW'(rel_len) : '0);
            msg_q  <= msg_q + (we ? MW'(1) : '0) - (rel_ok ? MW'(1) : '0);
            if (we)     wr_q <= wr_q + AW'(rec_len);
            if (rel_ok) rd_q <= rd_q + AW'(rel_len);
         end
         if (drop)           ovr_q <= 1'b1;
         else if (ovr_clear) ovr_q <= 1'b0;
      end
   end

   assign wr_ptr    = wr_q;
   assign rd_ptr    = rd_q;
   assign buf_ready = (msg_q != '0);
   assign overrun   = ovr_q;

   // R7
   empty_means_no_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_q == '0) |-> (used_q == '0));
   // R9
   used_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      used_q <= UW'(CAP));
   // R9
   drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !reset_mode && !clr && (used_q + UW'(rec_len) > UW'(CAP)))
      |=> (ovr_q && $stable(wr_q)));
   // R8
   empty_release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_req && msg_q == '0 && !frm_valid) |=> ($stable(rd_q) && msg_q == '0));
   // R10
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !ovr_clear) |=> ovr_q);
   // R11
   leave_reset_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !reset_mode) |=> (used_q == '0 && msg_q == '0 && wr_q == '0));
endmodule

// File: rtl/can_rx_pack_buf.sv
module can_rx_pack_buf
   import can_rxbuf_pkg::*;
#(
   parameter int CAP = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reset_mode,
   input  logic        frm_valid,
   input  logic        frm_ext,
   input  logic        frm_rtr,
   input  logic [3:0]  frm_dlc,
   input  logic [28:0] frm_id,
   input  logic [63:0] frm_data,
   input  logic        rel_req,
   input  logic        ovr_clear,
   input  logic [3:0]  win_off,
   output logic [7:0]  win_data,
   output logic        buf_ready,
   output logic        overrun
);
   localparam int AW = $clog2(CAP);

   if ((CAP & (CAP - 1)) != 0 || CAP < 16) begin : g_bad_cap
      $error("CAP must be a power of two and at least 16");
   end

   rec_bytes_t       rec;
   logic [LEN_W-1:0] rec_len;
   logic             clr, we;
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [7:0]       hdr;

   can_rxbuf_pack u_pack (
      .ext(frm_ext), .rtr(frm_rtr), .dlc(frm_dlc), .id(frm_id), .data(frm_data),
      .bytes(rec), .len(rec_len)
   );

   can_rxbuf_ctrl #(.CAP(CAP)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .frm_valid(frm_valid),
      .rec_len(rec_len), .rel_req(rel_req), .ovr_clear(ovr_clear), .hdr(hdr),
      .clr(clr), .we(we), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
      .buf_ready(buf_ready), .overrun(overrun)
   );

   can_rxbuf_store #(.CAP(CAP)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(we), .wr_base(wr_ptr),
      .wr_len(rec_len), .wr_bytes(rec), .rd_base(rd_ptr), .rd_off(win_off),
      .rd_data(win_data), .hdr(hdr)
   );
endmodule

// File: tb/can_rx_pack_buf_tb.sv
module can_rx_pack_buf_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CAPB = 64;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        reset_mode = 0;
   logic        frm_valid = 0, frm_ext = 0, frm_rtr = 0;
   logic [3:0]  frm_dlc = 0;
   logic [28:0] frm_id = 0;
   logic [63:0] frm_data = 0;
   logic        rel_req = 0, ovr_clear = 0;
   logic [3:0]  win_off = 0;
   logic [7:0]  win_data;
   logic        buf_ready, overrun;

   int checks = 0, errors = 0;
   logic [7:0] m_mem [CAPB];
   int m_wr = 0, m_rd = 0, m_used = 0, m_msgs = 0;
   bit m_ovr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_rx_pack_buf u_dut (
      .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .frm_valid(frm_valid),
      .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_id(frm_id),
      .frm_data(frm_data), .rel_req(rel_req), .ovr_clear(ovr_clear),
      .win_off(win_off), .win_data(win_data), .buf_ready(buf_ready), .overrun(overrun)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < CAPB; i++) m_mem[i] = 8'h00;
      m_wr = 0; m_rd = 0; m_used = 0; m_msgs = 0;
   endtask

   task automatic check_win(string tag);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         win_off = 4'(k);
         #1;
         chk(tag, {24'h0, win_data}, (k < 13) ? {24'h0, m_mem[(m_rd + k) % CAPB]} : 32'h0);
      end
      chk(tag, {31'h0, buf_ready}, {31'h0, m_msgs != 0});
      chk(tag, {31'h0, overrun}, {31'h0, m_ovr});
   endtask

   task automatic send(bit ext, bit rtr, logic [3:0] dlc, logic [28:0] id,
                       logic [63:0] data, bit clr_too = 0);
      logic [7:0] b [13];
      int dl, nd, n;
      @(negedge clk);
      frm_valid = 1; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc;
      frm_id = id; frm_data = data; ovr_clear = clr_too;
      dl = (dlc > 8) ? 8 : int'(dlc);
      nd = rtr ? 0 : dl;
      b[0] = {ext, rtr, 2'b00, 4'(dl)};
      if (ext) begin
         b[1] = id[28:21]; b[2] = id[20:13]; b[3] = id[12:5]; b[4] = {id[4:0], 3'b0};
         n = 5;
      end else begin
         b[1] = id[10:3]; b[2] = {id[2:0], 5'b0};
         n = 3;
      end
      for (int k = 0; k < nd; k++) b[n + k] = data[8*k +: 8];
      n = n + nd;
      if (!reset_mode) begin
         if (m_used + n > CAPB) m_ovr = 1;
         else begin
            for (int k = 0; k < n; k++) m_mem[(m_wr + k) % CAPB] = b[k];
            m_wr = (m_wr + n) % CAPB; m_used += n; m_msgs++;
            if (clr_too) m_ovr = 0;
         end
      end else if (clr_too) m_ovr = 0;
      @(negedge clk);
      frm_valid = 0; ovr_clear = 0;
   endtask

   task automatic release_one();
      logic [7:0] h;
      int n;
      @(negedge clk);
      rel_req = 1;
      if (m_msgs > 0) begin
         h = m_mem[m_rd];
         n = 3 + (h[7] ? 2 : 0) + (h[6] ? 0 : int'(h[3:0]));
         m_rd = (m_rd + n) % CAPB; m_used -= n; m_msgs--;
      end
      @(negedge clk);
      rel_req = 0;
   endtask

   task automatic t_reset();
      chk("R1 ready", {31'h0, buf_ready}, 0);
      chk("R1 overrun", {31'h0, overrun}, 0);
   endtask

   task automatic t_std();
      send(0, 0, 4'd3, 29'h5A3, 64'h0000_0000_00CC_BBAA);
      check_win("R2 standard record");
      check_win("R6 window");
   endtask

   task automatic t_ext();
      release_one();
      check_win("R7 release to empty");
      send(1, 0, 4'd2, 29'h1ABC_DEF5, 64'h0000_0000_0000_2211);
      check_win("R3 extended record");
   endtask

   task automatic t_rtr_and_clamp();
      send(0, 1, 4'd6, 29'h123, 64'hFFFF_FFFF_FFFF_FFFF);
      send(1, 1, 4'd4, 29'h0000_0ABC, 64'hFFFF_FFFF_FFFF_FFFF);
      send(0, 0, 4'd12, 29'h7FF, 64'h8877_6655_4433_2211);
      release_one();
      check_win("R4 remote standard");
      release_one();
      check_win("R4 remote extended");
      release_one();
      check_win("R5 length code clamp");
      release_one();
      check_win("R7 ready clears");
   endtask

   task automatic t_empty_release();
      release_one();
      release_one();
      check_win("R8 empty release");
      send(0, 0, 4'd1, 29'h055, 64'h5A);
      check_win("R8 pointer unchanged");
   endtask

   task automatic leave_reset();
      @(negedge clk); reset_mode = 1;
      @(negedge clk); reset_mode = 0;
      model_clear();
      @(negedge clk);
   endtask

   task automatic t_wrap();
      leave_reset();
      for (int i = 0; i < 5; i++) send(0, 0, 4'd8, 29'(29'h100 + i), 64'h0102_0304_0506_0700 + 64'(i));
      for (int i = 0; i < 3; i++) release_one();
      send(1, 0, 4'd8, 29'h1555_AAAA, 64'hF1F2_F3F4_F5F6_F7F8);
      release_one();
      release_one();
      check_win("R12 straddling record");
   endtask

   task automatic t_overrun();
      leave_reset();
      for (int i = 0; i < 4; i++) send(1, 0, 4'd8, 29'(29'h0100_0000 + i), 64'h1111_2222_3333_4444);
      send(1, 0, 4'd7, 29'h0ABC_0123, 64'h00EE_DDCC_BBAA_9988);
      check_win("R9 exact fill accepted");
      send(0, 1, 4'd0, 29'h001, 64'h0);
      check_win("R9 drop sets overrun");
   endtask

   task automatic t_reset_mode();
      @(negedge clk); reset_mode = 1;
      @(negedge clk);
      send(0, 0, 4'd2, 29'h321, 64'h4321);
      chk("R11 frame ignored in reset mode", {31'h0, buf_ready}, 1);
      @(negedge clk); reset_mode = 0;
      model_clear();
      @(negedge clk);
      check_win("R11 cleared on leave, overrun kept");
      @(negedge clk); reset_mode = 1;
      send(0, 0, 4'd2, 29'h321, 64'h4321);
      chk("R11 empty buffer ignores frame", {31'h0, buf_ready}, 0);
      @(negedge clk); reset_mode = 0;
      @(negedge clk);
   endtask

   task automatic t_clear_ovr();
      @(negedge clk); ovr_clear = 1;
      m_ovr = 0;
      @(negedge clk); ovr_clear = 0;
      check_win("R10 clear command");
      for (int i = 0; i < 4; i++) send(1, 0, 4'd8, 29'h0, 64'h0);
      send(1, 0, 4'd7, 29'h0, 64'h0);
      send(0, 0, 4'd0, 29'h7, 64'h0, 1);
      check_win("R10 set wins over clear");
      @(negedge clk); ovr_clear = 1;
      m_ovr = 0;
      @(negedge clk); ovr_clear = 0;
      check_win("R10 clear after tie");
   endtask

   bit done = 0;

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_std();
      t_ext();
      t_rtr_and_clamp();
      t_empty_release();
      t_wrap();
      t_overrun();
      t_reset_mode();
      t_clear_ovr();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired got running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule